// File: doc/BRIEF.md
# Character Display Power-Up and Text Sequencer

This block is a self-running master for a character display controller that is wired in 4-bit mode. After reset it plays the power-up sequence. That sequence is a fixed preamble of lone nibbles spaced only by timed waits, followed by five configuration bytes. The block then positions the cursor at the start of each of two display lines and writes a text string on each one. Timed waits are counted in clock cycles and scaled from a clock-frequency parameter, so the same netlist respects the microsecond rules at any clock rate.

Every byte goes out as two nibble writes, high nibble first, on a strobe/acknowledge port that carries a register-select bit. The block then polls the controller's status byte through a read request/acknowledge port until the busy bit clears. If the busy bit stays set past a retry budget, the block raises a sticky timeout flag and moves on. The two strings come from parameters, and a one-cycle done pulse marks the end of the text. Once that pulse has been given, the block accepts display-off and display-on requests for suspend and resume. A request that arrives while a byte is being sent waits until that byte has finished.

Top module: `lcd_init_seq`

## Requirements
- R1: After reset the block writes four lone nibbles with register select 0, in the order 0x3, 0x3, 0x3, 0x2. The gap after the first write is at least 5000 us, and the gaps after each of the other three are at least 100 us.
- R2: No status read is issued before the fourth preamble nibble has been written.
- R3: After the preamble the command bytes 0x28, 0x0C, 0x06, 0x01, 0x02 are sent in that order, with register select 0.
- R4: Each byte is sent as its high nibble (bits 7:4) and then its low nibble (bits 3:0), with the same register select on both. The low nibble follows the high one by at least 10 us. The first status read comes at least 100 us after the low nibble.
- R5: Bit 7 of the status byte is the busy bit. While it reads 1 the status is read again, up to MAX_RETRY extra reads (51 reads in total by default). A read with bit 7 clear ends the byte without an error.
- R6: If all 1+MAX_RETRY reads return busy, timeout_o is set. It stays set until reset, and the sequence continues with the next byte.
- R7: Before the text of line 0 the command 0x80 is sent, and before the text of line 1 the command 0xA8 (0x80 OR 0x28) is sent, both with register select 0. Text characters are sent with register select 1.
- R8: Each line writes its string characters in order. It stops at the first zero byte or after 40 characters, whichever comes first.
- R9: done_o pulses high for exactly one cycle, within a few cycles after the last character of line 1 has completed.
- R10: After the done pulse, a sleep_req_i pulse causes byte 0x08 to be sent and a wake_req_i pulse causes byte 0x0C to be sent, both with register select 0.
- R11: Sleep and wake requests made before the done pulse are dropped and never produce a byte.
- R12: A request made while a byte is in flight is held and sent after that byte finishes. A later request replaces one that is still held, so that only the most recent one is sent.
- R13: While reset is held, lcd_wr_o, lcd_rd_o, done_o and timeout_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_req_i | input | 1 | Request to switch the display off (one-cycle pulse) |
| wake_req_i | input | 1 | Request to switch the display on (one-cycle pulse) |
| lcd_wr_o | output | 1 | Nibble write strobe, held until acknowledged |
| lcd_rs_o | output | 1 | Register select: 0 command, 1 character data |
| lcd_nib_o | output | 4 | Nibble being written |
| lcd_wr_done_i | input | 1 | Nibble write acknowledge |
| lcd_rd_o | output | 1 | Status read request, held until acknowledged |
| lcd_rd_done_i | input | 1 | Status read acknowledge, with lcd_rd_data_i valid |
| lcd_rd_data_i | input | 8 | Status byte; bit 7 is busy |
| done_o | output | 1 | One-cycle pulse when both text lines are written |
| timeout_o | output | 1 | Sticky busy-retry exhaustion flag |

## Verification
A corrupted step or character index shows up on the nibble port as a byte that is missing, repeated or out of place, within one byte transfer, which is about 110 us plus the polling. A wrong delay counter shows up as an edge that comes too early in the timestamps of the acknowledged writes and reads. A miscounted retry budget shows up as the wrong number of status reads for a byte, or as a timeout flag that appears or stays missing at the next low-nibble write. A faulty request queue shows up after the done pulse, as a power byte that is absent, doubled or of the wrong value.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [2:0] {
    S_PRE, S_CFG, S_ADDR, S_TEXT, S_IDLE, S_PWR
  } seq_st_e;

  typedef enum logic [2:0] {
    X_IDLE, X_HI, X_GAP, X_LO, X_SETTLE, X_POLL
  } xfer_st_e;

  typedef struct packed {
    logic       rs;
    logic       single;     // lone high nibble, no busy poll
    logic       long_wait;  // lone nibble followed by the long wait
    logic [7:0] data;
  } xfer_req_t;

  localparam logic [7:0] CMD_DDRAM    = 8'h80;
  localparam logic [7:0] CMD_DISP_OFF = 8'h08;
  localparam logic [7:0] CMD_DISP_ON  = 8'h0C;
  localparam int         NUM_PRE      = 4;
  localparam int         NUM_CFG      = 5;

  function automatic logic [3:0] pre_nib(logic [1:0] i);
    return (i == 2'd3) ? 4'h2 : 4'h3;
  endfunction

  function automatic logic [7:0] cfg_byte(logic [2:0] i);
    case (i)
      3'd0:    return 8'h28;
      3'd1:    return 8'h0C;
      3'd2:    return 8'h06;
      3'd3:    return 8'h01;
      default: return 8'h02;
    endcase
  endfunction

endpackage

// File: rtl/lcd_text_rom.sv
module lcd_text_rom #(
  parameter int                     TEXT_BYTES = 16,
  parameter logic [8*TEXT_BYTES-1:0] TEXT0     = "HELLO",
  parameter logic [8*TEXT_BYTES-1:0] TEXT1     = "WORLD",
  parameter int                     IW         = 6
) (
  input  logic          line_i,
  input  logic [IW-1:0] idx_i,
  output logic [7:0]    chr_o
);

  // string literals are right-justified; skip the zero padding on top
  function automatic int lead_zero(logic [8*TEXT_BYTES-1:0] t);
    int  n;
    bit  hit;
    n   = 0;
    hit = 1'b0;
    for (int i = TEXT_BYTES - 1; i >= 0; i--) begin
      if (t[8*i +: 8] != 8'h00) hit = 1'b1;
      if (!hit) n++;
    end
    return n;
  endfunction

  logic [1:0][7:0] line_chr;

  for (genvar g = 0; g < 2; g++) begin : g_line
    localparam logic [8*TEXT_BYTES-1:0] TXT  = (g == 0) ? TEXT0 : TEXT1;
    localparam int                      LEAD = lead_zero(TXT);
    always_comb begin
      int pos;
      pos         = int'(idx_i) + LEAD;
      line_chr[g] = 8'h00;
      if (pos < TEXT_BYTES) line_chr[g] = TXT[8*(TEXT_BYTES-1-pos) +: 8];
    end
  end

  assign chr_o = line_chr[line_i];

endmodule

// File: rtl/lcd_nibble_xfer.sv
module lcd_nibble_xfer
  import lcd_seq_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int MAX_RETRY = 50
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  xfer_req_t req_i,
  output logic      done_o,
  output logic      tmo_o,
  output logic      wr_o,
  output logic      rs_o,
  output logic [3:0] nib_o,
  input  logic      wr_done_i,
  output logic      rd_o,
  input  logic      rd_done_i,
  input  logic      rd_busy_i
);

  localparam int CYC_US    = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int LONG_CYC  = 5000 * CYC_US;
  localparam int SHORT_CYC = 100 * CYC_US;
  localparam int GAP_CYC   = 10 * CYC_US;
  localparam int CW        = $clog2(LONG_CYC + 1);
  localparam int RW        = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);

  xfer_st_e  st_q;
  xfer_req_t req_q;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] try_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= X_IDLE;
      req_q  <= '0;
      cnt_q  <= '0;
      try_q  <= '0;
      done_o <= 1'b0;
      tmo_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      tmo_o  <= 1'b0;
      case (st_q)
        X_IDLE: if (start_i) begin
          req_q <= req_i;
          st_q  <= X_HI;
        end
        X_HI: if (wr_done_i) begin
          if (req_q.single) begin
            cnt_q <= req_q.long_wait ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
            st_q  <= X_SETTLE;
          end else begin
            cnt_q <= CW'(GAP_CYC - 1);
            st_q  <= X_GAP;
          end
        end
        X_GAP: begin
          if (cnt_q == '0) st_q <= X_LO;
          else             cnt_q <= cnt_q - CW'(1);
        end
        X_LO: if (wr_done_i) begin
          cnt_q <= CW'(SHORT_CYC - 1);
          st_q  <= X_SETTLE;
        end
        X_SETTLE: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
          end else if (req_q.single) begin
            done_o <= 1'b1;
            st_q   <= X_IDLE;
          end else begin
            try_q <= '0;
            st_q  <= X_POLL;
          end
        end
        X_POLL: if (rd_done_i) begin
          if (!rd_busy_i) begin
            done_o <= 1'b1;
            st_q   <= X_IDLE;
          end else if (try_q == RW'(MAX_RETRY)) begin
            done_o <= 1'b1;
            tmo_o  <= 1'b1;
            st_q   <= X_IDLE;
          end else begin
            try_q <= try_q + RW'(1);
          end
        end
        default: st_q <= X_IDLE;
      endcase
    end
  end

  assign wr_o  = (st_q == X_HI) || (st_q == X_LO);
  assign nib_o = (st_q == X_LO) ? req_q.data[3:0] : req_q.data[7:4];
  assign rs_o  = req_q.rs;
  assign rd_o  = (st_q == X_POLL);

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_seq_pkg::*;
#(
  parameter int                      CLK_HZ     = 50_000_000,
  parameter int                      MAX_RETRY  = 50,
  parameter int                      LINE_CHARS = 40,
  parameter logic [6:0]              LINE1_ADDR = 7'h28,
  parameter int                      TEXT_BYTES = 16,
  parameter logic [8*TEXT_BYTES-1:0] TEXT0      = "HELLO",
  parameter logic [8*TEXT_BYTES-1:0] TEXT1      = "WORLD"
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_req_i,
  input  logic       wake_req_i,
  output logic       lcd_wr_o,
  output logic       lcd_rs_o,
  output logic [3:0] lcd_nib_o,
  input  logic       lcd_wr_done_i,
  output logic       lcd_rd_o,
  input  logic       lcd_rd_done_i,
  input  logic [7:0] lcd_rd_data_i,
  output logic       done_o,
  output logic       timeout_o
);

  localparam int IW = ($clog2(LINE_CHARS + 1) < 3) ? 3 : $clog2(LINE_CHARS + 1);

  seq_st_e       st_q;
  logic [IW-1:0] idx_q;
  logic          line_q, wait_q, pend_q, pend_on_q, done_q, tmo_q;
  logic          go, xfer_done, xfer_tmo, text_end;
  xfer_req_t     req;
  logic [7:0]    chr;
  logic          unused_rd;

  assign unused_rd = ^lcd_rd_data_i[6:0];

  lcd_text_rom #(
    .TEXT_BYTES(TEXT_BYTES), .TEXT0(TEXT0), .TEXT1(TEXT1), .IW(IW)
  ) u_rom (
    .line_i(line_q), .idx_i(idx_q), .chr_o(chr)
  );

  assign text_end = (chr == 8'h00) || (idx_q == IW'(LINE_CHARS));

  always_comb begin
    req = '0;
    go  = 1'b0;
    case (st_q)
      S_PRE: begin
        req.single    = 1'b1;
        req.long_wait = (idx_q == '0);
        req.data      = {pre_nib(idx_q[1:0]), 4'h0};
        go            = !wait_q;
      end
      S_CFG: begin
        req.data = cfg_byte(idx_q[2:0]);
        go       = !wait_q;
      end
      S_ADDR: begin
        req.data = CMD_DDRAM | {1'b0, line_q ? LINE1_ADDR : 7'h00};
        go       = !wait_q;
      end
      S_TEXT: begin
        req.rs   = 1'b1;
        req.data = chr;
        go       = !wait_q && !text_end;
      end
      S_IDLE: begin
        req.data = pend_on_q ? CMD_DISP_ON : CMD_DISP_OFF;
        go       = pend_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_PRE;
      idx_q     <= '0;
      line_q    <= 1'b0;
      wait_q    <= 1'b0;
      pend_q    <= 1'b0;
      pend_on_q <= 1'b0;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (xfer_tmo) tmo_q <= 1'b1;
      if (go)       wait_q <= 1'b1;
      case (st_q)
        S_PRE: if (xfer_done) begin
          wait_q <= 1'b0;
          if (idx_q == IW'(NUM_PRE - 1)) begin
            st_q  <= S_CFG;
            idx_q <= '0;
          end else idx_q <= idx_q + IW'(1);
        end
        S_CFG: if (xfer_done) begin
          wait_q <= 1'b0;
          if (idx_q == IW'(NUM_CFG - 1)) begin
            st_q   <= S_ADDR;
            idx_q  <= '0;
            line_q <= 1'b0;
          end else idx_q <= idx_q + IW'(1);
        end
        S_ADDR: if (xfer_done) begin
          wait_q <= 1'b0;
          idx_q  <= '0;
          st_q   <= S_TEXT;
        end
        S_TEXT: begin
          if (xfer_done) begin
            wait_q <= 1'b0;
            idx_q  <= idx_q + IW'(1);
          end else if (!wait_q && text_end) begin
            if (line_q) begin
              st_q   <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              line_q <= 1'b1;
              st_q   <= S_ADDR;
            end
          end
        end
        S_IDLE: if (pend_q) begin
          pend_q <= 1'b0;
          st_q   <= S_PWR;
        end
        S_PWR: if (xfer_done) begin
          wait_q <= 1'b0;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
      // power requests only after init; latest one wins
      if (st_q == S_IDLE || st_q == S_PWR) begin
        if (sleep_req_i) begin
          pend_q    <= 1'b1;
          pend_on_q <= 1'b0;
        end
        if (wake_req_i) begin
          pend_q    <= 1'b1;
          pend_on_q <= 1'b1;
        end
      end
    end
  end

  lcd_nibble_xfer #(
    .CLK_HZ(CLK_HZ), .MAX_RETRY(MAX_RETRY)
  ) u_xfer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (go),
    .req_i    (req),
    .done_o   (xfer_done),
    .tmo_o    (xfer_tmo),
    .wr_o     (lcd_wr_o),
    .rs_o     (lcd_rs_o),
    .nib_o    (lcd_nib_o),
    .wr_done_i(lcd_wr_done_i),
    .rd_o     (lcd_rd_o),
    .rd_done_i(lcd_rd_done_i),
    .rd_busy_i(lcd_rd_data_i[7])
  );

  assign done_o    = done_q;
  assign timeout_o = tmo_q;

endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sleep_req_i,
  input logic       wake_req_i,
  input logic       lcd_wr_o,
  input logic       lcd_rs_o,
  input logic [3:0] lcd_nib_o,
  input logic       lcd_wr_done_i,
  input logic       lcd_rd_o,
  input logic       lcd_rd_done_i,
  input logic [7:0] lcd_rd_data_i,
  input logic       done_o,
  input logic       timeout_o
);

  logic [2:0] wr_cnt_q;
  logic       unused_chk;

  assign unused_chk = ^{sleep_req_i, wake_req_i, lcd_rd_data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_cnt_q <= '0;
    else if (lcd_wr_o && lcd_wr_done_i && wr_cnt_q != 3'd4) wr_cnt_q <= wr_cnt_q + 3'd1;
  end

  p_no_poll_pre_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cnt_q != 3'd4) |-> !lcd_rd_o);

  p_port_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lcd_wr_o && lcd_rd_o));

  p_wr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcd_wr_o && !lcd_wr_done_i) |=> (lcd_wr_o && $stable(lcd_nib_o) && $stable(lcd_rs_o)));

  p_rd_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcd_rd_o && !lcd_rd_done_i) |=> lcd_rd_o);

  p_tmo_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> timeout_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

bind lcd_init_seq lcd_init_seq_chk u_chk (.*);

// File: tb/tb_lcd_init_seq.sv
module tb_lcd_init_seq;

  localparam int TB_BYTES = 48;
  localparam int NB       = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, wake_req = 1'b0;
  logic wr, rs, rd, done, tmo;
  logic [3:0] nib;
  logic wr_done = 1'b0, rd_done = 1'b0;
  logic [7:0] rd_data = 8'h00;

  always #2 clk = ~clk;

  lcd_init_seq #(
    .CLK_HZ(1_000_000), .MAX_RETRY(50), .LINE_CHARS(40), .TEXT_BYTES(TB_BYTES),
    .TEXT0("Ready 1"),
    .TEXT1("ABCDEFGHIJKLMNOPQRSTUVWXYZabcdefghijklmnopqr")
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .wake_req_i(wake_req),
    .lcd_wr_o(wr), .lcd_rs_o(rs), .lcd_nib_o(nib), .lcd_wr_done_i(wr_done),
    .lcd_rd_o(rd), .lcd_rd_done_i(rd_done), .lcd_rd_data_i(rd_data),
    .done_o(done), .timeout_o(tmo)
  );

  string s0 = "Ready 1";
  string s1 = "ABCDEFGHIJKLMNOPQRSTUVWXYZabcdefghijklmnopqr";

  int total = 0, bad = 0;
  int cyc = 0, nib_cnt = 0, nbytes = 0, pre_reads = 0, busy_left = 0;
  int done_cnt = 0, done_t = 0;
  logic [3:0] pre_v [4];
  logic       pre_rs [4];
  int         pre_t [4];
  logic [3:0] hi_v;
  logic       hi_rs;
  logic [7:0] byt [NB];
  logic       brs [NB];
  logic       rs_ok [NB];
  logic       tmo_lo [NB];
  int hi_t [NB], lo_t [NB], rd_cnt [NB], first_rd [NB], last_rd [NB];

  // controller model, acting away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (done) begin done_cnt++; done_t = cyc; end
    if (wr && !wr_done) begin
      wr_done = 1'b1;
      if (nib_cnt < 4) begin
        pre_v[nib_cnt] = nib; pre_rs[nib_cnt] = rs; pre_t[nib_cnt] = cyc;
      end else if (((nib_cnt - 4) % 2) == 0) begin
        hi_v = nib; hi_rs = rs; hi_t[(nib_cnt - 4) / 2] = cyc;
      end else begin
        automatic int b = (nib_cnt - 4) / 2;
        byt[b] = {hi_v, nib}; brs[b] = rs; rs_ok[b] = (rs == hi_rs);
        lo_t[b] = cyc; tmo_lo[b] = tmo; rd_cnt[b] = 0; first_rd[b] = 0;
        busy_left = (b == 0) ? 50 : (b == 1) ? 1000 : 2;
        nbytes = b + 1;
      end
      nib_cnt++;
    end else wr_done = 1'b0;
    if (rd && !rd_done) begin
      rd_done = 1'b1;
      rd_data = (busy_left > 0) ? 8'h85 : 8'h05;
      if (busy_left > 0) busy_left--;
      if (nbytes == 0) pre_reads++;
      else begin
        if (rd_cnt[nbytes-1] == 0) first_rd[nbytes-1] = cyc;
        rd_cnt[nbytes-1]++;
        last_rd[nbytes-1] = cyc;
      end
    end else rd_done = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input bit on);
    @(negedge clk);
    if (on) wake_req = 1'b1; else sleep_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0; sleep_req = 1'b0;
  endtask

  task automatic test_reset;
    wait_cyc(5);
    chk(!wr && !rd, "R13 strobes low in reset", {wr, rd}, 0);
    chk(!done && !tmo, "R13 flags low in reset", {done, tmo}, 0);
    rst_n = 1'b1;
  endtask

  task automatic test_boot;
    while (nbytes < 3) @(negedge clk);
    pulse(1'b0);  // early requests, must be dropped (R11)
    pulse(1'b1);
    while (done_cnt == 0) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk(pre_v[i] == ((i == 3) ? 4'h2 : 4'h3), "R1 preamble nibble", pre_v[i], (i == 3) ? 2 : 3);
      chk(pre_rs[i] == 1'b0, "R1 preamble rs", pre_rs[i], 0);
    end
    chk(pre_t[1] - pre_t[0] >= 5000, "R1 long wait", pre_t[1] - pre_t[0], 5000);
    chk(pre_t[2] - pre_t[1] >= 100, "R1 wait 2", pre_t[2] - pre_t[1], 100);
    chk(pre_t[3] - pre_t[2] >= 100, "R1 wait 3", pre_t[3] - pre_t[2], 100);
    chk(hi_t[0] - pre_t[3] >= 100, "R1 wait 4", hi_t[0] - pre_t[3], 100);
    chk(pre_reads == 0, "R2 no poll in preamble", pre_reads, 0);
    begin
      automatic logic [7:0] cfg [5] = '{8'h28, 8'h0C, 8'h06, 8'h01, 8'h02};
      for (int i = 0; i < 5; i++)
        chk(byt[i] == cfg[i] && brs[i] == 1'b0, "R3 config byte", byt[i], cfg[i]);
    end
    begin
      automatic int bad_gap = 0, bad_set = 0, bad_rs = 0;
      for (int b = 0; b < nbytes; b++) begin
        if (lo_t[b] - hi_t[b] < 10) bad_gap++;
        if (first_rd[b] - lo_t[b] < 100) bad_set++;
        if (!rs_ok[b]) bad_rs++;
      end
      chk(bad_gap == 0, "R4 nibble gap", bad_gap, 0);
      chk(bad_set == 0, "R4 settle before poll", bad_set, 0);
      chk(bad_rs == 0, "R4 rs equal on both nibbles", bad_rs, 0);
    end
    chk(rd_cnt[0] == 51, "R5 reads until clear at limit", rd_cnt[0], 51);
    chk(tmo_lo[1] == 1'b0, "R5 no timeout when clear", tmo_lo[1], 0);
    chk(rd_cnt[2] == 3, "R5 reads with two busy", rd_cnt[2], 3);
    chk(rd_cnt[1] == 51, "R6 reads on exhaustion", rd_cnt[1], 51);
    chk(tmo_lo[2] == 1'b1, "R6 timeout raised", tmo_lo[2], 1);
    chk(tmo == 1'b1, "R6 timeout sticky", tmo, 1);
    chk(byt[5] == 8'h80 && brs[5] == 1'b0, "R7 line0 address", byt[5], 8'h80);
    chk(byt[13] == 8'hA8 && brs[13] == 1'b0, "R7 line1 address", byt[13], 8'hA8);
    for (int i = 0; i < 7; i++)
      chk(byt[6+i] == s0[i] && brs[6+i], "R8 line0 char", byt[6+i], s0[i]);
    for (int i = 0; i < 40; i++)
      chk(byt[14+i] == s1[i] && brs[14+i], "R8 line1 char", byt[14+i], s1[i]);
    chk(nbytes == 54, "R8 byte count at done", nbytes, 54);
    chk(done_t - last_rd[53] >= 1 && done_t - last_rd[53] <= 6, "R9 done timing",
        done_t - last_rd[53], 3);
    wait_cyc(400);
    chk(done_cnt == 1, "R9 single done pulse", done_cnt, 1);
    chk(nbytes == 54, "R11 early requests dropped", nbytes, 54);
  endtask

  task automatic test_sleep_wake;
    pulse(1'b0);
    wait_cyc(400);
    chk(nbytes == 55 && byt[54] == 8'h08 && !brs[54], "R10 sleep byte", byt[54], 8'h08);
    pulse(1'b1);
    wait_cyc(400);
    chk(nbytes == 56 && byt[55] == 8'h0C && !brs[55], "R10 wake byte", byt[55], 8'h0C);
  endtask

  task automatic test_queue;
    pulse(1'b0);
    wait_cyc(5);
    pulse(1'b1);
    wait_cyc(600);
    chk(byt[56] == 8'h08, "R12 first in flight", byt[56], 8'h08);
    chk(byt[57] == 8'h0C, "R12 queued after", byt[57], 8'h0C);
    chk(nbytes == 58, "R12 count after queue", nbytes, 58);
    pulse(1'b1);
    wait_cyc(5);
    pulse(1'b0);
    pulse(1'b1);
    wait_cyc(600);
    chk(byt[58] == 8'h0C && byt[59] == 8'h0C, "R12 latest wins", byt[59], 8'h0C);
    chk(nbytes == 60, "R12 count latest wins", nbytes, 60);
  endtask

  bit finished = 1'b0;

  initial begin
    test_reset();
    test_boot();
    test_sleep_wake();
    test_queue();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule